// File: doc/BRIEF.md
# Overlapping 1-0-1 Serial Pattern Recognizer

The recognizer watches a one-bit serial stream, sampling one bit per rising clock edge, and reports each place where the last three bits form 1, 0, 1. Matches may share bits, so the stream 1 0 1 0 1 produces two matches.

Two recognizers run side by side on the same clock and reset. The first holds its decision in a four-state register, so its match flag depends on the state alone. That flag turns on for the whole clock period after the edge that samples the closing 1. The second merges the two states that behave the same on the next input into one, which leaves three states. Its match flag is a combinational function of state and the bit being presented. As a result it announces a match one clock earlier than the four-state path, in the same cycle as the closing bit.

Both state vectors are brought out for debug. A parameter selects whether the next-state logic is written as Boolean equations or as a transition table. Both forms must behave the same.

Top module: `rec101_detector`

## Requirements
- R1: While `rst_n` is low, both state outputs read 00 and both match flags read 0. This takes effect at once, without waiting for a clock edge.
- R2: The four-state code on `moore_state` is as follows. 00 means no progress. 01 means the last sampled bit was 1 and did not complete a match. 10 means the last two sampled bits were 1 then 0. 11 means the last three sampled bits were 1, 0, 1.
- R3: The four-state transitions, written as state/input -> next state, are: 00/0->00, 00/1->01, 01/0->10, 01/1->01, 10/0->00, 10/1->11, 11/0->10, 11/1->01.
- R4: `moore_hit` is 1 exactly while `moore_state` is 11. It is therefore high for one full clock period after the edge that samples the closing 1 of a match.
- R5: Overlapping matches are all reported. For the stream 1 0 1 0 1, both flags fire for the third bit and again for the fifth bit.
- R6: The three-state code on `mealy_state` is as follows. 01 means the last sampled bit was 1. 10 means the last two sampled bits were 1 then 0. 00 means any other history.
- R7: `mealy_hit` is 1 exactly when `mealy_state` is 10 and `bit_in` is 1, in the same cycle as that bit. It therefore rises one clock before `moore_hit` for the same match.
- R8: `mealy_state` never reads 11. If code 11 were ever held, the next clock edge would return it to 00.
- R9: For the stream 1 1 0 1 0 1 1 0 0, matches are reported for the fourth and the sixth bit only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one stream bit is sampled per edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the clock domain |
| bit_in | input | 1 | Serial stream bit |
| moore_hit | output | 1 | Registered match flag of the four-state path |
| mealy_hit | output | 1 | Combinational match flag of the three-state path |
| moore_state | output | 2 | Debug view of the four-state register |
| mealy_state | output | 2 | Debug view of the three-state register |

## Verification
The bench builds two copies of the block. One uses `NS_FORM = 0`, which gives equation-style next-state logic. The other uses `NS_FORM = 1`, which gives table-style next-state logic. Both copies are compared every cycle against one history-based expectation, so a slip in either variant shows up, and so does any disagreement between the two variants. Directed streams cover overlapping matches, long runs of ones and zeros, and the nine-bit example. A reset applied in the middle of a stream confirms that reset clears state without waiting for a clock edge. A long random stream then exercises every transition of both machines many times.

// File: rtl/rec101_pkg.sv
package rec101_pkg;

  // width of every state vector in the block
  localparam int STATE_W = 2;

  // four-state path codes (code 11 is the accepting state)
  localparam logic [STATE_W-1:0] MO_IDLE    = 2'b00;
  localparam logic [STATE_W-1:0] MO_ONE     = 2'b01;
  localparam logic [STATE_W-1:0] MO_ONEZERO = 2'b10;
  localparam logic [STATE_W-1:0] MO_MATCH   = 2'b11;

  // three-state path codes (11 is illegal)
  localparam logic [STATE_W-1:0] ML_IDLE    = 2'b00;
  localparam logic [STATE_W-1:0] ML_ONE     = 2'b01;
  localparam logic [STATE_W-1:0] ML_ONEZERO = 2'b10;
  localparam logic [STATE_W-1:0] ML_BAD     = 2'b11;

  // next-state description variants
  localparam int NS_EQUATIONS = 0;
  localparam int NS_TABLE     = 1;

endpackage

// File: rtl/rec101_moore_path.sv
module rec101_moore_path
  import rec101_pkg::*;
#(
  parameter int NS_FORM = NS_EQUATIONS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_in,
  output logic [STATE_W-1:0] state_q,
  output logic               hit
);

  logic [STATE_W-1:0] state_d;
  logic               sa;
  logic               sb;

  assign sa = state_q[1];
  assign sb = state_q[0];

  generate
    if (NS_FORM == NS_EQUATIONS) begin : g_eqn
      always_comb begin
        state_d[1] = (~bit_in & sb) | (bit_in & sa & ~sb);
        state_d[0] = bit_in;
      end
    end else begin : g_tbl
      always_comb begin
        state_d = MO_IDLE;
        unique case (state_q)
          MO_IDLE:    state_d = bit_in ? MO_ONE   : MO_IDLE;
          MO_ONE:     state_d = bit_in ? MO_ONE   : MO_ONEZERO;
          MO_ONEZERO: state_d = bit_in ? MO_MATCH : MO_IDLE;
          MO_MATCH:   state_d = bit_in ? MO_ONE   : MO_ONEZERO;
          default:    state_d = MO_IDLE;
        endcase
      end
    end
  endgenerate

  // state register: asynchronous clear, clocked update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MO_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // output decoded from state only
  always_comb begin
    hit = sa & sb;
  end

endmodule

// File: rtl/rec101_mealy_path.sv
module rec101_mealy_path
  import rec101_pkg::*;
#(
  parameter int NS_FORM = NS_EQUATIONS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_in,
  output logic [STATE_W-1:0] state_q,
  output logic               hit
);

  logic [STATE_W-1:0] state_d;
  logic               legal;

  assign legal = (state_q != ML_BAD);

  generate
    if (NS_FORM == NS_EQUATIONS) begin : g_eqn
      always_comb begin
        if (legal) begin
          state_d[1] = ~bit_in & state_q[0];
          state_d[0] = bit_in;
        end else begin
          state_d = ML_IDLE;
        end
      end
    end else begin : g_tbl
      always_comb begin
        state_d = ML_IDLE;
        unique case (state_q)
          ML_IDLE:    state_d = bit_in ? ML_ONE : ML_IDLE;
          ML_ONE:     state_d = bit_in ? ML_ONE : ML_ONEZERO;
          ML_ONEZERO: state_d = bit_in ? ML_ONE : ML_IDLE;
          default:    state_d = ML_IDLE;
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ML_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // output depends on state and the bit being presented
  always_comb begin
    hit = bit_in & state_q[1] & ~state_q[0];
  end

endmodule

// File: rtl/rec101_detector.sv
module rec101_detector
  import rec101_pkg::*;
#(
  parameter int NS_FORM = NS_EQUATIONS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_in,
  output logic               moore_hit,
  output logic               mealy_hit,
  output logic [STATE_W-1:0] moore_state,
  output logic [STATE_W-1:0] mealy_state
);

  rec101_moore_path #(
    .NS_FORM (NS_FORM)
  ) u_moore (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_in  (bit_in),
    .state_q (moore_state),
    .hit     (moore_hit)
  );

  rec101_mealy_path #(
    .NS_FORM (NS_FORM)
  ) u_mealy (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_in  (bit_in),
    .state_q (mealy_state),
    .hit     (mealy_hit)
  );

endmodule

// File: rtl/rec101_checker.sv
module rec101_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_in,
  input logic       moore_hit,
  input logic       mealy_hit,
  input logic [1:0] moore_state,
  input logic [1:0] mealy_state
);

  // R1: reset holds both registers at 00
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (moore_state == 2'b00 && mealy_state == 2'b00 &&
                                !moore_hit && !mealy_hit);
    end
  end

  // R3: 10 followed by a 1 reaches the accepting code
  p_accept_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (moore_state == 2'b10 && bit_in) |=> (moore_state == 2'b11));

  // R4: a rise of the registered flag follows an accepting step
  p_hit_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(moore_hit) |-> ($past(moore_state) == 2'b10 && $past(bit_in)));

  // R6: the two paths track the same recent history
  p_paths_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mealy_state[0] == moore_state[0]) &&
    ((mealy_state == 2'b10) == (moore_state == 2'b10)));

  // R7: the combinational flag leads the registered flag by one clock
  p_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mealy_hit |=> moore_hit);

  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mealy_hit |=> !moore_hit);

  // R8: illegal code never appears
  p_legal_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mealy_state != 2'b11);

endmodule

bind rec101_detector rec101_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_in      (bit_in),
  .moore_hit   (moore_hit),
  .mealy_hit   (mealy_hit),
  .moore_state (moore_state),
  .mealy_state (mealy_state)
);

// File: tb/sim_rec101_detector.sv
`timescale 1ns/1ps
module sim_rec101_detector;

  typedef struct packed {
    logic       mo_hit;
    logic       me_hit;
    logic [1:0] mo_st;
    logic [1:0] me_st;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       bit_in;
  logic       mo_hit0, me_hit0, mo_hit1, me_hit1;
  logic [1:0] mo_st0, me_st0, mo_st1, me_st1;

  int   n_checks;
  int   n_fail;
  bit   done;
  logic [2:0] hist;   // hist[0] = most recently sampled bit
  exp_t sb_q[$];

  rec101_detector #(.NS_FORM(0)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in),
    .moore_hit(mo_hit0), .mealy_hit(me_hit0),
    .moore_state(mo_st0), .mealy_state(me_st0)
  );

  rec101_detector #(.NS_FORM(1)) u1 (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in),
    .moore_hit(mo_hit1), .mealy_hit(me_hit1),
    .moore_state(mo_st1), .mealy_state(me_st1)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: present one bit, push what the outputs must show this cycle
  task automatic drive_bit(input logic b);
    exp_t e;
    @(negedge clk);
    bit_in = b;
    if (hist[0]) e.mo_st = (hist[2:1] == 2'b10) ? 2'b11 : 2'b01;
    else         e.mo_st = hist[1] ? 2'b10 : 2'b00;
    e.me_st  = hist[0] ? 2'b01 : (hist[1] ? 2'b10 : 2'b00);
    e.mo_hit = (e.mo_st == 2'b11);
    e.me_hit = b & ~hist[0] & hist[1];
    sb_q.push_back(e);
    hist = {hist[1:0], b};
  endtask

  task automatic drive_str(input string s);
    for (int i = 0; i < s.len(); i++) drive_bit(s[i] == "1");
  endtask

  // reset asserted away from a clock edge, checked before any edge (R1)
  task automatic apply_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    bit_in = 1'b0;
    hist   = 3'b000;
    #1;
    check("R1 u0 moore_state", mo_st0, 2'b00);
    check("R1 u0 mealy_state", me_st0, 2'b00);
    check("R1 u1 moore_state", mo_st1, 2'b00);
    check("R1 u0 hits", {mo_hit0, me_hit0}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: compare both copies against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check("R4 R5 R9 u0 moore_hit", {1'b0, mo_hit0}, {1'b0, e.mo_hit});
        check("R7 R5 R9 u0 mealy_hit", {1'b0, me_hit0}, {1'b0, e.me_hit});
        check("R2 R3 u0 moore_state",  mo_st0, e.mo_st);
        check("R6 u0 mealy_state",     me_st0, e.me_st);
        check("R4 R5 R9 u1 moore_hit", {1'b0, mo_hit1}, {1'b0, e.mo_hit});
        check("R7 R5 R9 u1 mealy_hit", {1'b0, me_hit1}, {1'b0, e.me_hit});
        check("R2 R3 u1 moore_state",  mo_st1, e.mo_st);
        check("R6 u1 mealy_state",     me_st1, e.me_st);
        check("R8 u0 legal code", {1'b0, me_st0 == 2'b11}, 2'b00);
      end
    end
  end

  // watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    hist     = 3'b000;
    rst_n    = 1'b0;
    bit_in   = 1'b0;
    repeat (3) @(posedge clk);
    apply_reset();

    drive_str("10101");        // R5 overlapping matches
    drive_str("000");
    drive_str("111101");       // match on sixth bit
    apply_reset();
    drive_str("110101100");    // R9 worked example
    drive_str("1111111100000000");
    drive_str("1001010110101");
    drive_str("1010");
    apply_reset();             // R1 reset in the middle of progress
    drive_str("01101");

    for (int i = 0; i < 4000; i++) drive_bit(1'($urandom_range(0, 1)));
    drive_str("000");
    @(negedge clk);
    #2;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule